// File: doc/BRIEF.md
# Byte-command Wishbone pipelined master

This block turns a stream of bytes into single Wishbone B4 pipelined bus cycles. A host sends a framed command over an incoming byte channel. The channel carries a data byte with a one-cycle valid strobe. The block parses the command, runs one 32-bit bus cycle, and sends back status bytes on an outgoing byte channel that uses a valid/ready handshake. It sits between a serial or USB byte transport and an on-chip Wishbone bus, so a host can peek and poke registers without a parallel register interface.

A frame starts with an opcode byte. A write opcode is followed by four address bytes and four data bytes. A read opcode is followed by four address bytes. A bus-reset opcode stands alone. Every multi-byte field travels most significant byte first. The status byte is 0xA0 for success and 0xAF for failure. A read always answers with four data bytes followed by the status byte. A bus cycle that hangs is cut off by a timeout. The host can also abandon it early by sending the bus-reset opcode.

Top module: `bytecmd_wb_master`

## Requirements
- R1: While reset is asserted and right after it is released, `wb_cyc_o`, `wb_stb_o` and `out_valid` are low.
- R2: Opcode 0x01 followed by address bytes A3..A0 and data bytes D3..D0 (MSB first) starts one bus cycle after the last data byte. The cycle has `wb_we_o`=1, `wb_adr_o`={A3..A0}, `wb_dat_o`={D3..D0} and `wb_sel_o` all ones. An ACK answers it with the single byte 0xA0.
- R3: Opcode 0x02 followed by address bytes A3..A0 starts a bus cycle with `wb_we_o`=0. An ACK answers it with the four bytes of `wb_dat_i` captured with the ACK, MSB first, then 0xA0.
- R4: Opcode 0x00 received while no command is in progress is answered with the single byte 0xA0.
- R5: Any opcode other than 0x00, 0x01 or 0x02 is answered with 0xAF and leaves the parser idle, so the next byte is taken as an opcode.
- R6: A cycle that ends with ERR is answered with 0xAF. For a read, four 0x00 data bytes precede the 0xAF.
- R7: A cycle that has seen no ACK or ERR after 256 cycles with `wb_cyc_o` high is dropped at that point. It is answered like an error: 0xAF, with four 0x00 bytes first for a read.
- R8: `wb_stb_o` is high only inside `wb_cyc_o`. It stays high while `wb_stall_i` is high and falls the cycle after it is accepted. `wb_cyc_o` stays high until ACK, ERR, timeout or abort.
- R9: A 0x00 byte that arrives while a bus cycle is outstanding drops `wb_cyc_o` on the next cycle and is answered with the single byte 0xA0. This takes priority over an ACK or ERR in the same cycle, whose result is then discarded.
- R10: `out_valid` stays high with `out_data` stable until `out_ready` is high. Each accepted byte moves to the next byte of the response.
- R11: Bytes that arrive while a response is still waiting to be accepted, and non-0x00 bytes that arrive during a bus cycle, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Incoming command byte |
| in_valid | input | 1 | One-cycle strobe marking `in_data` valid |
| out_data | output | 8 | Response byte |
| out_valid | output | 1 | Response byte present |
| out_ready | input | 1 | Downstream accepts the response byte |
| wb_cyc_o | output | 1 | Bus cycle in progress |
| wb_stb_o | output | 1 | Request strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | 32 | Bus address |
| wb_dat_o | output | 32 | Write data |
| wb_sel_o | output | 4 | Byte lane selects, all ones |
| wb_dat_i | input | 32 | Read data |
| wb_ack_i | input | 1 | Cycle acknowledge |
| wb_err_i | input | 1 | Cycle error |
| wb_stall_i | input | 1 | Slave cannot take the request |

## Verification
A bus-reset byte from the host and an ACK from the slave can land in the same clock cycle. The abort must win, and the late read data must be thrown away. The bench provokes this by leaving a read cycle without any answer from the slave. It then drives the 0x00 byte and a forced ACK carrying 0xDEADBEEF on the same cycle. The run passes if the only response is a single 0xA0, `wb_cyc_o` is low on the next cycle, and a following read returns the correct data.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
  localparam logic [7:0] OP_BUSRST = 8'h00;
  localparam logic [7:0] OP_WRITE  = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h02;
  localparam logic [7:0] RSP_OK    = 8'hA0;
  localparam logic [7:0] RSP_FAIL  = 8'hAF;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_ADDR,
    PS_DATA,
    PS_BUS
  } ps_e;
endpackage

// File: rtl/bcw_ctrl.sv
module bcw_ctrl
  import bcw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  input  logic              tx_busy,
  input  logic              fin,
  input  logic              ok,
  input  logic [DATA_W-1:0] rdata,
  output logic              go,
  output logic              abort,
  output logic              we_o,
  output logic [ADDR_W-1:0] adr_o,
  output logic [DATA_W-1:0] dat_o,
  output logic              ld,
  output logic              ld_long,
  output logic [7:0]        ld_code,
  output logic [DATA_W-1:0] ld_data
);
  localparam int NAB  = ADDR_W / 8;
  localparam int NDB  = DATA_W / 8;
  localparam int MAXB = (NAB > NDB) ? NAB : NDB;
  localparam int CW   = $clog2(MAXB) + 1;

  ps_e               st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              we_q, we_d;
  logic              adr_en, dat_en, is_rst;

  assign is_rst = (in_data == OP_BUSRST);
  assign adr_en = (st_q == PS_ADDR) && in_valid;
  assign dat_en = (st_q == PS_DATA) && in_valid;
  assign adr_d  = {adr_q[ADDR_W-9:0], in_data};
  assign dat_d  = {dat_q[DATA_W-9:0], in_data};

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    we_d    = we_q;
    go      = 1'b0;
    abort   = 1'b0;
    ld      = 1'b0;
    ld_long = 1'b0;
    ld_code = RSP_OK;
    ld_data = '0;
    case (st_q)
      PS_IDLE: begin
        if (in_valid && !tx_busy) begin
          cnt_d = '0;
          if (in_data == OP_WRITE) begin
            st_d = PS_ADDR;
            we_d = 1'b1;
          end else if (in_data == OP_READ) begin
            st_d = PS_ADDR;
            we_d = 1'b0;
          end else begin
            ld      = 1'b1;
            ld_code = is_rst ? RSP_OK : RSP_FAIL;
          end
        end
      end
      PS_ADDR: begin
        if (in_valid) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(NAB - 1)) begin
            cnt_d = '0;
            if (we_q) begin
              st_d = PS_DATA;
            end else begin
              st_d = PS_BUS;
              go   = 1'b1;
            end
          end
        end
      end
      PS_DATA: begin
        if (in_valid) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(NDB - 1)) begin
            cnt_d = '0;
            st_d  = PS_BUS;
            go    = 1'b1;
          end
        end
      end
      PS_BUS: begin
        if (in_valid && is_rst) begin
          abort   = 1'b1;
          ld      = 1'b1;
          ld_code = RSP_OK;
          st_d    = PS_IDLE;
        end else if (fin) begin
          ld      = 1'b1;
          ld_long = !we_q;
          ld_code = ok ? RSP_OK : RSP_FAIL;
          ld_data = ok ? rdata : '0;
          st_d    = PS_IDLE;
        end
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      cnt_q <= '0;
      we_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      we_q  <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q <= '0;
      dat_q <= '0;
    end else begin
      if (adr_en) adr_q <= adr_d;
      if (dat_en) dat_q <= dat_d;
    end
  end

  assign we_o  = we_q;
  assign adr_o = adr_q;
  assign dat_o = dat_q;
endmodule

// File: rtl/bcw_bus.sv
module bcw_bus #(
  parameter int TIMEOUT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic abort,
  input  logic ack_i,
  input  logic err_i,
  input  logic stall_i,
  output logic cyc_o,
  output logic stb_o,
  output logic fin_o,
  output logic ok_o
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic          cyc_q, cyc_d, stb_q, stb_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          tmo_hit, en;

  assign tmo_hit = (tmo_q == TW'(TIMEOUT - 1));
  assign fin_o   = cyc_q && (ack_i || err_i || tmo_hit);
  assign ok_o    = ack_i && !err_i;
  assign en      = go || cyc_q;

  always_comb begin
    cyc_d = cyc_q;
    stb_d = stb_q;
    tmo_d = tmo_q;
    if (go) begin
      cyc_d = 1'b1;
      stb_d = 1'b1;
      tmo_d = '0;
    end else if (abort || fin_o) begin
      cyc_d = 1'b0;
      stb_d = 1'b0;
      tmo_d = '0;
    end else begin
      tmo_d = tmo_q + 1'b1;
      if (stb_q && !stall_i) stb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= 1'b0;
      stb_q <= 1'b0;
      tmo_q <= '0;
    end else if (en) begin
      cyc_q <= cyc_d;
      stb_q <= stb_d;
      tmo_q <= tmo_d;
    end
  end

  assign cyc_o = cyc_q;
  assign stb_o = stb_q;
endmodule

// File: rtl/bcw_resp.sv
module bcw_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              ld_long,
  input  logic [7:0]        ld_code,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_valid,
  output logic              busy
);
  localparam int BW = DATA_W + 8;
  localparam int NB = DATA_W / 8 + 1;
  localparam int NW = $clog2(NB + 1);

  logic [BW-1:0] sh_q, sh_d;
  logic [NW-1:0] n_q, n_d;
  logic          pop, en;

  assign out_valid = (n_q != '0);
  assign pop       = out_valid && out_ready;
  assign en        = ld || pop;

  always_comb begin
    sh_d = sh_q;
    n_d  = n_q;
    if (ld) begin
      sh_d = ld_long ? {ld_data, ld_code} : {ld_code, {DATA_W{1'b0}}};
      n_d  = ld_long ? NW'(NB) : NW'(1);
    end else if (pop) begin
      sh_d = {sh_q[BW-9:0], 8'h00};
      n_d  = n_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      n_q  <= '0;
    end else if (en) begin
      sh_q <= sh_d;
      n_q  <= n_d;
    end
  end

  assign out_data = sh_q[BW-1 -: 8];
  assign busy     = out_valid;
endmodule

// File: rtl/bytecmd_wb_master.sv
module bytecmd_wb_master #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          in_data,
  input  logic                in_valid,
  output logic [7:0]          out_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                wb_cyc_o,
  output logic                wb_stb_o,
  output logic                wb_we_o,
  output logic [ADDR_W-1:0]   wb_adr_o,
  output logic [DATA_W-1:0]   wb_dat_o,
  output logic [DATA_W/8-1:0] wb_sel_o,
  input  logic [DATA_W-1:0]   wb_dat_i,
  input  logic                wb_ack_i,
  input  logic                wb_err_i,
  input  logic                wb_stall_i
);
  localparam int SEL_W = DATA_W / 8;

  logic              go, abort, fin, ok, tx_busy;
  logic              ld, ld_long;
  logic [7:0]        ld_code;
  logic [DATA_W-1:0] ld_data;

  bcw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .tx_busy(tx_busy), .fin(fin), .ok(ok), .rdata(wb_dat_i),
    .go(go), .abort(abort), .we_o(wb_we_o), .adr_o(wb_adr_o), .dat_o(wb_dat_o),
    .ld(ld), .ld_long(ld_long), .ld_code(ld_code), .ld_data(ld_data)
  );

  bcw_bus #(.TIMEOUT(TIMEOUT)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort),
    .ack_i(wb_ack_i), .err_i(wb_err_i), .stall_i(wb_stall_i),
    .cyc_o(wb_cyc_o), .stb_o(wb_stb_o), .fin_o(fin), .ok_o(ok)
  );

  bcw_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_long(ld_long), .ld_code(ld_code),
    .ld_data(ld_data), .out_ready(out_ready), .out_data(out_data),
    .out_valid(out_valid), .busy(tx_busy)
  );

  for (genvar g = 0; g < SEL_W; g++) begin : g_sel
    assign wb_sel_o[g] = 1'b1;
  end
endmodule

// File: rtl/bcw_chk.sv
module bcw_chk #(
  parameter int TIMEOUT = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] in_data,
  input logic       in_valid,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       cyc,
  input logic       stb,
  input logic       ack,
  input logic       err,
  input logic       stall
);
  int len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= 0;
    else if (cyc) len_q <= len_q + 1;
    else len_q <= 0;
  end

  a_r8_stb_in_cyc: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> cyc);

  a_r8_stb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stb && stall |=> stb);

  a_r8_cyc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cyc && !ack && !err && !in_valid && (len_q < TIMEOUT - 1) |=> cyc);

  a_r7_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cyc |-> (len_q < TIMEOUT));

  a_r9_abort_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cyc && in_valid && (in_data == 8'h00) |=> !cyc);

  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind bytecmd_wb_master bcw_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
  .cyc(wb_cyc_o), .stb(wb_stb_o), .ack(wb_ack_i), .err(wb_err_i),
  .stall(wb_stall_i)
);

// File: tb/bytecmd_wb_master_bench.sv
module bytecmd_wb_master_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  in_data;
  logic        in_valid;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready;
  logic        wb_cyc, wb_stb, wb_we;
  logic [31:0] wb_adr, wb_dat_o, wb_dat_i;
  logic [3:0]  wb_sel;
  logic        wb_ack_i, wb_err, wb_stall;

  logic        ack_s, ack_force;
  logic [31:0] sdat, force_dat;

  assign wb_ack_i = ack_s | ack_force;
  assign wb_dat_i = ack_force ? force_dat : sdat;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bytecmd_wb_master u_bytecmd_wb_master (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .wb_cyc_o(wb_cyc), .wb_stb_o(wb_stb), .wb_we_o(wb_we), .wb_adr_o(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel), .wb_dat_i(wb_dat_i),
    .wb_ack_i(wb_ack_i), .wb_err_i(wb_err), .wb_stall_i(wb_stall)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit c, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // slave model
  int s_stall = 0, s_lat = 0;
  bit s_err = 0, s_noack = 0;
  int ph = 0, scnt = 0, cyc_len = 0, stb_len = 0;
  logic [31:0] rec_adr, rec_dat;
  logic        rec_we;
  logic [3:0]  rec_sel;
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : ~a;
  endfunction

  task automatic answer();
    if (!s_noack) begin
      ph = 2;
      if (s_err) wb_err = 1'b1;
      else begin
        ack_s = 1'b1;
        if (rec_we) mem[rec_adr] = rec_dat;
        else sdat = rd(rec_adr);
      end
    end
  endtask

  initial begin
    wb_stall = 0; ack_s = 0; wb_err = 0; sdat = '0;
    forever begin
      @(negedge clk);
      ack_s = 0; wb_err = 0;
      if (!wb_cyc) begin
        ph = 0; scnt = 0; wb_stall = 0;
      end else begin
        cyc_len++;
        if (wb_stb) stb_len++;
        if (ph == 0) begin
          if (scnt < s_stall) begin
            wb_stall = 1; scnt++;
          end else begin
            wb_stall = 0;
            rec_adr = wb_adr; rec_dat = wb_dat_o; rec_we = wb_we; rec_sel = wb_sel;
            ph = 1; scnt = 0;
            if (s_lat == 0) answer();
          end
        end else if (ph == 1) begin
          wb_stall = 0;
          scnt++;
          if (scnt >= s_lat) answer();
        end
      end
    end
  end

  // ready driver
  int rdy_mode = 0;
  int rk = 0;
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      rk++;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = (rk % 3) != 0;
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    logic [7:0] e;
    string t;
    bit hold_v;
    logic [7:0] hold_d;
    hold_v = 0; hold_d = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_v) chk(out_valid && out_data == hold_d, "R10", "held byte", out_data, hold_d);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(0, "R10", "unexpected byte", out_data, 0);
          else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_data == e, t, "response byte", out_data, e);
          end
        end
        hold_v = out_valid && !out_ready;
        hold_d = out_data;
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_data = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send(w[31 - 8*i -: 8]);
  endtask

  task automatic expect_b(input logic [7:0] b, input string tag);
    exp_q.push_back(b); tag_q.push_back(tag);
  endtask

  task automatic expect_word(input logic [31:0] w, input string tag);
    for (int i = 0; i < 4; i++) expect_b(w[31 - 8*i -: 8], tag);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    send(8'h01); send_word(a); send_word(d);
  endtask

  task automatic do_read(input logic [31:0] a);
    send(8'h02); send_word(a);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_slave(input int st, input int lat, input bit er, input bit na);
    s_stall = st; s_lat = lat; s_err = er; s_noack = na;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_data = '0; in_valid = 1'b0; ack_force = 1'b0; force_dat = '0;
    repeat (3) @(negedge clk);
    chk(!wb_cyc && !wb_stb && !out_valid, "R1", "idle in reset",
        {wb_cyc, wb_stb, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wb_cyc && !wb_stb && !out_valid, "R1", "idle after reset",
        {wb_cyc, wb_stb, out_valid}, 0);

    // R2 write
    set_slave(0, 0, 0, 0);
    expect_b(8'hA0, "R2");
    do_write(32'h1234_5678, 32'hCAFE_F00D);
    drain();
    chk(rec_adr == 32'h1234_5678, "R2", "write address", rec_adr, 32'h1234_5678);
    chk(rec_dat == 32'hCAFE_F00D, "R2", "write data", rec_dat, 32'hCAFE_F00D);
    chk(rec_we == 1'b1 && rec_sel == 4'hF, "R2", "we/sel", {rec_we, rec_sel}, 5'h1F);

    // R3 read back
    expect_word(32'hCAFE_F00D, "R3"); expect_b(8'hA0, "R3");
    do_read(32'h1234_5678);
    drain();
    chk(rec_we == 1'b0, "R3", "read we", rec_we, 0);

    // R8 stall + latency, R10 backpressure pattern
    set_slave(3, 2, 0, 0);
    rdy_mode = 1;
    stb_len = 0;
    expect_b(8'hA0, "R8");
    do_write(32'h0000_0010, 32'h0102_0304);
    drain();
    chk(stb_len == 4, "R8", "stb cycles under stall", stb_len, 4);
    expect_word(32'h0102_0304, "R10"); expect_b(8'hA0, "R10");
    do_read(32'h0000_0010);
    drain();
    rdy_mode = 0;
    set_slave(0, 1, 0, 0);

    // R3 unwritten address
    expect_word(32'hFFFF_FF00, "R3"); expect_b(8'hA0, "R3");
    do_read(32'h0000_00FF);
    drain();

    // R4 bus reset when idle
    expect_b(8'hA0, "R4");
    send(8'h00);
    drain();

    // R5 unknown opcode then a normal read
    expect_b(8'hAF, "R5");
    send(8'h7E);
    expect_word(32'h0102_0304, "R5"); expect_b(8'hA0, "R5");
    do_read(32'h0000_0010);
    drain();

    // R6 error
    set_slave(0, 1, 1, 0);
    expect_b(8'hAF, "R6");
    do_write(32'h0000_0040, 32'h1111_2222);
    drain();
    expect_word(32'h0, "R6"); expect_b(8'hAF, "R6");
    do_read(32'h0000_0010);
    drain();

    // R7 timeout with an ignored byte mid-cycle (R11)
    set_slave(0, 0, 0, 1);
    cyc_len = 0;
    expect_word(32'h0, "R7"); expect_b(8'hAF, "R7");
    do_read(32'h0000_0020);
    send(8'h05);
    drain();
    chk(cyc_len == 256, "R7", "cycles before timeout", cyc_len, 256);

    // R9 abort of a hung write
    expect_b(8'hA0, "R9");
    do_write(32'h0000_0030, 32'h5555_5555);
    @(negedge clk);
    in_data = 8'h00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!wb_cyc, "R9", "cyc after abort", wb_cyc, 0);
    drain();

    // R9 abort and ACK in the same cycle
    expect_b(8'hA0, "R9");
    do_read(32'h0000_0010);
    while (wb_stb) @(negedge clk);
    in_data = 8'h00; in_valid = 1'b1; ack_force = 1'b1; force_dat = 32'hDEAD_BEEF;
    @(negedge clk);
    in_valid = 1'b0; ack_force = 1'b0;
    chk(!wb_cyc, "R9", "cyc after abort with ack", wb_cyc, 0);
    drain();
    set_slave(0, 0, 0, 0);
    expect_word(32'h0102_0304, "R9"); expect_b(8'hA0, "R9");
    do_read(32'h0000_0010);
    drain();

    // R11 byte ignored while a response waits
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    expect_b(8'hA0, "R11");
    send(8'h00);
    send(8'h01);
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == 8'hA0, "R11", "pending response", out_data, 8'hA0);
    rdy_mode = 0;
    drain();
    expect_word(32'h0102_0304, "R11"); expect_b(8'hA0, "R11");
    do_read(32'h0000_0010);
    drain();

    chk(exp_q.size() == 0, "R10", "leftover expected bytes", exp_q.size(), 0);
    finish_run();
  end
endmodule